// File: doc/BRIEF.md
# Register Stack Push/Pop Sequencer

This block carries out the one-byte stack opcodes of a 32-bit integer core. A push takes a value from an eight-entry general register file and writes it to a byte-wide data memory below the current stack pointer. A pop reads a word from the stack and puts it into a chosen register. The stack pointer is not a dedicated counter: it is entry 4 of the same register file, so pushing or popping that entry has its own, well-defined outcome.

Each 32-bit word moves as four single-byte beats, least significant byte at the lowest address. The memory port is synchronous: a read issued in one cycle returns its byte in the next. A request is one cycle of `start` with an opcode while `busy` is low. The rest of the core reaches the register file through one write port and one read port. The write port is honoured only while the engine is idle.

The request side is a plain pulse/busy handshake rather than a valid/ready stream. There is no back-pressure: a `start` seen while `busy` is high is dropped, not held. The caller must wait for `busy` low, or for the `done` pulse, before it issues the next request.

Top module: `stk_engine`

## Requirements
- R1: An opcode whose upper five bits are 01010 (0x50..0x57) is a push and one with upper bits 01011 (0x58..0x5F) is a pop; in both the register index is opcode bits [2:0]; any other opcode given with `start` is ignored (busy stays low, no memory beat, no register change).
- R2: A push writes the pushed word at address SP-4 and leaves SP (register 4) equal to its old value minus 4.
- R3: Words are little-endian: beat k (k = 0..3) accesses address base+k and carries bits [8k+7:8k], beats in increasing address order.
- R4: A pop reads the word at address SP, writes it to the selected register, and leaves SP equal to its old value plus 4.
- R5: Pushing register 4 stores the stack pointer value held before the decrement.
- R6: Popping into register 4 leaves register 4 equal to the loaded word; the +4 adjustment is overridden.
- R7: After an accepted request `busy` is high for exactly five cycles: four memory beats, then one register-update cycle. `done` is high for exactly one cycle, the first cycle after `busy` falls, and the registers already hold the new values then.
- R8: A `start` while `busy` is high is ignored: no extra operation, no extra memory beat.
- R9: After reset `busy`, `done` and `mem_en` are low and every register reads zero.
- R10: The external register write port has no effect while `busy` is high. The external read port returns the addressed register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| start | input | 1 | request strobe, sampled when idle |
| opcode | input | 8 | stack opcode qualified by start |
| busy | output | 1 | operation in progress |
| done | output | 1 | one-cycle completion pulse |
| mem_en | output | 1 | memory beat enable |
| mem_we | output | 1 | beat is a write (1) or read (0) |
| mem_addr | output | 32 | byte address of the beat |
| mem_wdata | output | 8 | write byte |
| mem_rdata | input | 8 | read byte, valid the cycle after a read beat |
| ext_we | input | 1 | external register write |
| ext_widx | input | 3 | external write index |
| ext_wdata | input | 32 | external write data |
| ext_ridx | input | 3 | external read index |
| ext_rdata | output | 32 | external read data |

## Verification
Directed cases use the small stack-pointer example and a one-byte value, which shows whether the byte order and the pointer update order are right. Pushing and popping register 4 show whether the engine reads the pointer before it changes and whether the loaded value wins over the +4 adjustment. Opcodes outside the stack range, and new requests and register writes injected mid-operation, show whether the idle gating really ignores them. Random runs of mixed pushes and pops over random register contents check every index, and they show whether a pop returns the bytes an earlier push laid down.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [1:0] {
    S_IDLE   = 2'd0,
    S_BEAT   = 2'd1,
    S_COMMIT = 2'd2
  } seq_state_t;

  localparam logic [7:0] OP_PUSH_BASE = 8'h50;
  localparam logic [7:0] OP_POP_BASE  = 8'h58;
endpackage

// File: rtl/stk_decode.sv
module stk_decode
  import stk_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic [7:0]       opcode,
  output logic             legal,
  output logic             is_pop,
  output logic [IDX_W-1:0] idx
);
  localparam int GRP_W = 8 - IDX_W;

  logic hit_push, hit_pop;

  always_comb begin
    hit_push = (opcode[7:IDX_W] == OP_PUSH_BASE[7:IDX_W]);
    hit_pop  = (opcode[7:IDX_W] == OP_POP_BASE[7:IDX_W]);
    legal    = hit_push | hit_pop;
    is_pop   = hit_pop;
    idx      = opcode[IDX_W-1:0];
  end

  initial begin
    assert (GRP_W > 0) else $error("index field too wide");
  end
endmodule

// File: rtl/stk_regfile.sv
module stk_regfile #(
  parameter int NREG   = 8,
  parameter int DATA_W = 32,
  parameter int IDX_W  = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  // port a: highest priority (loaded word)
  input  logic              we_a,
  input  logic [IDX_W-1:0]  idx_a,
  input  logic [DATA_W-1:0] data_a,
  // port b: pointer update
  input  logic              we_b,
  input  logic [IDX_W-1:0]  idx_b,
  input  logic [DATA_W-1:0] data_b,
  // port c: external write
  input  logic              we_c,
  input  logic [IDX_W-1:0]  idx_c,
  input  logic [DATA_W-1:0] data_c,
  input  logic [IDX_W-1:0]  ridx_x,
  output logic [DATA_W-1:0] rdata_x,
  input  logic [IDX_W-1:0]  ridx_y,
  output logic [DATA_W-1:0] rdata_y,
  input  logic [IDX_W-1:0]  ridx_z,
  output logic [DATA_W-1:0] rdata_z
);
  logic [DATA_W-1:0] regs_q [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n)                             regs_q[i] <= '0;
      else if (we_a && idx_a == IDX_W'(i))    regs_q[i] <= data_a;
      else if (we_b && idx_b == IDX_W'(i))    regs_q[i] <= data_b;
      else if (we_c && idx_c == IDX_W'(i))    regs_q[i] <= data_c;
    end
  end

  assign rdata_x = regs_q[ridx_x];
  assign rdata_y = regs_q[ridx_y];
  assign rdata_z = regs_q[ridx_z];
endmodule

// File: rtl/stk_seq.sv
module stk_seq
  import stk_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 3,
  parameter int SP_IDX = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              legal,
  input  logic              is_pop,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] src_val,
  input  logic [DATA_W-1:0] sp_val,
  output logic              busy,
  output logic              done,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  output logic              wr_data_en,
  output logic [IDX_W-1:0]  wr_data_idx,
  output logic [DATA_W-1:0] wr_data_val,
  output logic              wr_sp_en,
  output logic [IDX_W-1:0]  wr_sp_idx,
  output logic [DATA_W-1:0] wr_sp_val
);
  localparam int BEATS  = DATA_W / 8;
  localparam int CNT_W  = $clog2(BEATS);
  localparam int WORD_B = BEATS * 4 / 4;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_B);

  seq_state_t        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              pop_q;
  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] base_q;
  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] sp_new_q;
  logic              rd_pend_q;
  logic [CNT_W-1:0]  rd_ptr_q;
  logic              done_q;
  logic              accept;
  logic [7:0]        wlane [BEATS];
  logic [7:0]        rlane_q [BEATS-1];
  logic [DATA_W-1:0] word_in;

  assign accept = (state_q == S_IDLE) && start && legal;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      cnt_q    <= '0;
      pop_q    <= 1'b0;
      idx_q    <= '0;
      base_q   <= '0;
      data_q   <= '0;
      sp_new_q <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= (state_q == S_COMMIT);
      unique case (state_q)
        S_IDLE: begin
          if (accept) begin
            state_q <= S_BEAT;
            cnt_q   <= '0;
            pop_q   <= is_pop;
            idx_q   <= idx;
            if (is_pop) begin
              base_q   <= ADDR_W'(sp_val);
              sp_new_q <= sp_val + DATA_W'(STEP);
              data_q   <= '0;
            end else begin
              base_q   <= ADDR_W'(sp_val - DATA_W'(STEP));
              sp_new_q <= sp_val - DATA_W'(STEP);
              data_q   <= src_val;   // old pointer when idx is SP_IDX
            end
          end
        end
        S_BEAT: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_W'(BEATS - 1)) state_q <= S_COMMIT;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // read-return tracking: byte arrives one cycle after its beat
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_pend_q <= 1'b0;
      rd_ptr_q  <= '0;
    end else begin
      rd_pend_q <= mem_en && !mem_we;
      rd_ptr_q  <= cnt_q;
    end
  end

  for (genvar k = 0; k < BEATS; k++) begin : g_wlane
    assign wlane[k] = data_q[8*k +: 8];
  end

  for (genvar k = 0; k < BEATS - 1; k++) begin : g_rlane
    always_ff @(posedge clk) begin
      if (!rst_n)                                     rlane_q[k] <= '0;
      else if (rd_pend_q && rd_ptr_q == CNT_W'(k))    rlane_q[k] <= mem_rdata;
    end
    assign word_in[8*k +: 8] = rlane_q[k];
  end
  assign word_in[DATA_W-1 -: 8] = mem_rdata;

  assign busy      = (state_q != S_IDLE);
  assign done      = done_q;
  assign mem_en    = (state_q == S_BEAT);
  assign mem_we    = mem_en && !pop_q;
  assign mem_addr  = base_q + ADDR_W'(cnt_q);
  assign mem_wdata = wlane[cnt_q];

  assign wr_data_en  = (state_q == S_COMMIT) && pop_q;
  assign wr_data_idx = idx_q;
  assign wr_data_val = word_in;
  assign wr_sp_en    = (state_q == S_COMMIT);
  assign wr_sp_idx   = IDX_W'(SP_IDX);
  assign wr_sp_val   = sp_new_q;

  // R7: done is a single-cycle pulse
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7: done only right after busy falls
  a_r7_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> !busy && $past(busy));
  // R7: memory beats happen only while busy
  a_r7_beat_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> busy);
  // R3: consecutive beats step the address upward by one
  a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en && $past(mem_en) |-> mem_addr == $past(mem_addr) + 1'b1);
  // R3: write direction is steady across a whole operation
  a_r3_dir_stable: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en && $past(mem_en) |-> $stable(mem_we));
  // R8: a busy operation is never cut short by a new start
  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en && $past(mem_en) && start |=> busy);
  // R1: an illegal opcode in idle never raises busy
  a_r1_illegal_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start && !legal |=> !busy);
endmodule

// File: rtl/stk_engine.sv
module stk_engine #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int NREG   = 8,
  parameter int SP_IDX = 4,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [7:0]        opcode,
  output logic              busy,
  output logic              done,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  input  logic              ext_we,
  input  logic [IDX_W-1:0]  ext_widx,
  input  logic [DATA_W-1:0] ext_wdata,
  input  logic [IDX_W-1:0]  ext_ridx,
  output logic [DATA_W-1:0] ext_rdata
);
  logic              legal, is_pop;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] src_val, sp_val;
  logic              wa_en, wb_en;
  logic [IDX_W-1:0]  wa_idx, wb_idx;
  logic [DATA_W-1:0] wa_val, wb_val;
  logic              ext_ok;

  stk_decode #(.IDX_W(IDX_W)) u_dec (
    .opcode (opcode),
    .legal  (legal),
    .is_pop (is_pop),
    .idx    (idx)
  );

  assign ext_ok = ext_we && !busy;

  stk_regfile #(.NREG(NREG), .DATA_W(DATA_W)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_a    (wa_en),
    .idx_a   (wa_idx),
    .data_a  (wa_val),
    .we_b    (wb_en),
    .idx_b   (wb_idx),
    .data_b  (wb_val),
    .we_c    (ext_ok),
    .idx_c   (ext_widx),
    .data_c  (ext_wdata),
    .ridx_x  (idx),
    .rdata_x (src_val),
    .ridx_y  (IDX_W'(SP_IDX)),
    .rdata_y (sp_val),
    .ridx_z  (ext_ridx),
    .rdata_z (ext_rdata)
  );

  stk_seq #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W),
    .SP_IDX (SP_IDX)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .legal       (legal),
    .is_pop      (is_pop),
    .idx         (idx),
    .src_val     (src_val),
    .sp_val      (sp_val),
    .busy        (busy),
    .done        (done),
    .mem_en      (mem_en),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_rdata   (mem_rdata),
    .wr_data_en  (wa_en),
    .wr_data_idx (wa_idx),
    .wr_data_val (wa_val),
    .wr_sp_en    (wb_en),
    .wr_sp_idx   (wb_idx),
    .wr_sp_val   (wb_val)
  );

  // R10: an external write attempted during an operation leaves no trace at commit
  a_r10_ext_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    busy && ext_we && !wa_en && !wb_en && ext_widx != IDX_W'(SP_IDX) |=> $stable(u_rf.regs_q[ext_widx]) || !$stable(ext_widx));
  // R9/R7: done and busy are never high together
  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy));
endmodule

// File: tb/test_stk_engine.sv
module test_stk_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  opcode = 8'h00;
  logic        busy, done, mem_en, mem_we;
  logic [31:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = 8'h00;
  logic        ext_we = 1'b0;
  logic [2:0]  ext_widx = 3'd0;
  logic [31:0] ext_wdata = 32'd0;
  logic [2:0]  ext_ridx = 3'd0;
  logic [31:0] ext_rdata;

  int n_chk = 0;
  int n_err = 0;
  logic [7:0]  mem [256];
  logic [31:0] mreg [8];
  logic [7:0]  emem [256];

  always #2 clk = ~clk;

  stk_engine i_stk_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
    .busy(busy), .done(done), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .ext_we(ext_we), .ext_widx(ext_widx), .ext_wdata(ext_wdata),
    .ext_ridx(ext_ridx), .ext_rdata(ext_rdata)
  );

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[7:0]];
    end
  end

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] rdreg_dummy(input logic [31:0] v);
    return v;
  endfunction

  task automatic read_reg(input int i, output logic [31:0] v);
    ext_ridx = 3'(i);
    #1;
    v = ext_rdata;
  endtask

  task automatic wr_reg(input int i, input logic [31:0] v);
    @(negedge clk);
    ext_we = 1'b1; ext_widx = 3'(i); ext_wdata = v;
    @(negedge clk);
    ext_we = 1'b0;
    mreg[i] = v;
  endtask

  task automatic cmp_regs(input string rq);
    logic [31:0] v;
    for (int i = 0; i < 8; i++) begin
      read_reg(i, v);
      chk(v === mreg[i], rq, v, mreg[i]);
    end
  endtask

  // expected-state model built from the requirements
  task automatic model(input logic [7:0] op);
    int ix;
    logic [31:0] sp, val;
    ix = int'(op[2:0]);
    sp = mreg[4];
    if (op[7:3] == 5'b01010) begin
      val = mreg[ix];
      sp = sp - 32'd4;
      for (int k = 0; k < 4; k++) emem[8'(sp + 32'(k))] = val[8*k +: 8];
      mreg[4] = sp;
    end else if (op[7:3] == 5'b01011) begin
      for (int k = 0; k < 4; k++) val[8*k +: 8] = emem[8'(sp + 32'(k))];
      mreg[4] = sp + 32'd4;
      mreg[ix] = val;
    end
  endtask

  // issue one stack op; optionally inject a new start and ext write mid-flight
  task automatic do_op(input logic [7:0] op, input string rq, input bit inject);
    int nb, nm;
    logic [31:0] sp0;
    sp0 = mreg[4];
    @(negedge clk);
    start = 1'b1; opcode = op;
    @(negedge clk);
    start = 1'b0;
    nb = 0; nm = 0;
    while (busy && nb < 20) begin
      nb++;
      if (mem_en) nm++;
      if (inject && nb == 2) begin
        start = 1'b1; opcode = 8'h50; ext_we = 1'b1; ext_widx = 3'd0; ext_wdata = 32'hDEAD_BEEF;
      end else begin
        start = 1'b0; ext_we = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0; ext_we = 1'b0;
    chk(nb == 5, "R7 busy cycles", 32'(nb), 32'd5);
    chk(nm == 4, "R7 beat count", 32'(nm), 32'd4);
    chk(done === 1'b1, "R7 done pulse", {31'd0, done}, 32'd1);
    model(op);
    cmp_regs(rq);
    if (op[7:3] == 5'b01010) begin
      for (int k = 0; k < 4; k++) begin
        logic [7:0] a;
        a = 8'(sp0 - 32'd4 + 32'(k));
        chk(mem[a] === emem[a], "R3 stored byte", {24'd0, mem[a]}, {24'd0, emem[a]});
      end
    end
    @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0, "R7 done single", {30'd0, done, busy}, 32'd0);
  endtask

  initial begin
    logic [31:0] v;
    logic [31:0] s;
    s = $urandom(32'd4242);
    for (int a = 0; a < 256; a++) begin mem[a] = 8'h00; emem[a] = 8'h00; end
    for (int i = 0; i < 8; i++) mreg[i] = 32'd0;
    repeat (3) @(negedge clk);
    chk(busy === 1'b0, "R9 busy", {31'd0, busy}, 32'd0);
    chk(done === 1'b0, "R9 done", {31'd0, done}, 32'd0);
    chk(mem_en === 1'b0, "R9 mem_en", {31'd0, mem_en}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    cmp_regs("R9 reset regs");

    // R2/R3 push example: SP 0x64 -> 0x60, bytes 0A 00 00 00
    wr_reg(4, 32'h64);
    wr_reg(3, 32'h0A);
    do_op(8'h53, "R2 push", 1'b0);
    chk(mem[8'h60] === 8'h0A && mem[8'h61] === 8'h00 && mem[8'h63] === 8'h00, "R3 little-endian",
        {mem[8'h63], mem[8'h62], mem[8'h61], mem[8'h60]}, 32'h0000000A);
    read_reg(4, v);
    chk(v === 32'h60, "R2 sp after push", v, 32'h60);
    // R4 pop example
    wr_reg(3, 32'h0);
    do_op(8'h5B, "R4 pop", 1'b0);
    read_reg(3, v);
    chk(v === 32'h0A, "R4 popped value", v, 32'h0A);
    read_reg(4, v);
    chk(v === 32'h64, "R4 sp after pop", v, 32'h64);
    // R5 push SP stores old SP
    do_op(8'h54, "R5 push sp", 1'b0);
    chk({mem[8'h63], mem[8'h62], mem[8'h61], mem[8'h60]} === 32'h64, "R5 stored old sp",
        {mem[8'h63], mem[8'h62], mem[8'h61], mem[8'h60]}, 32'h64);
    // R6 pop into SP: loaded value wins
    wr_reg(1, 32'h0000_0090);
    do_op(8'h51, "R6 setup push", 1'b0);
    do_op(8'h5C, "R6 pop sp", 1'b0);
    read_reg(4, v);
    chk(v === 32'h90, "R6 sp = loaded", v, 32'h90);
    // R1 illegal opcode ignored
    @(negedge clk);
    start = 1'b1; opcode = 8'h40;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b0 && mem_en === 1'b0, "R1 illegal ignored", {30'd0, busy, mem_en}, 32'd0);
    cmp_regs("R1 regs unchanged");
    // R8/R10 injection mid-operation
    wr_reg(0, 32'h1111_2222);
    do_op(8'h50, "R10 ext write blocked", 1'b1);
    chk(busy === 1'b0, "R8 no extra op", {31'd0, busy}, 32'd0);
    // random mix
    for (int n = 0; n < 60; n++) begin
      logic [7:0] op;
      if (($urandom % 4) == 0) wr_reg(1 + ($urandom % 3), $urandom);
      op = 8'h50 + 8'($urandom % 16);
      do_op(op, op[3] ? "R4 random pop" : "R2 random push", 1'b0);
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule